// File: doc/BRIEF.md
# Linear Bypass Interconnect for a PE Array

This block is the neighbour network of a linear array of processing elements (PEs). Each PE holds one mask bit, the top of its mask stack. A PE whose bit is set is active and takes part in neighbour transfers. A PE whose bit is clear is bypassed. Values pass through a bypassed PE untouched, so the nearest active PEs on either side of it behave as direct neighbours even when they are far apart physically.

A transfer request makes every PE drive one outgoing value. The value comes from the PE's own register data, from the global broadcast word or from the global immediate word. On the same clock edge, each active PE captures the value driven by its nearest active neighbour in the chosen direction. If an active PE has no such neighbour, it captures zero and raises its "no neighbour" flag. Bypassed PEs keep their captured value and their flag.

A two-state controller sequences the transfer. ST_IDLE waits. The transition IDLE_TO_DONE fires on a request. ST_DONE lasts one cycle and signals completion. From ST_DONE, DONE_TO_DONE fires on a new request and DONE_TO_IDLE fires when no request is present.

Top module: `bypnet_top`

## Requirements
- R1: After reset every received word is zero, every no-neighbour flag is 0, and done_o is 0.
- R2: The outgoing value is chosen by src_sel_i: 2'b00 gives the PE's own reg_i word, 2'b01 gives bcast_i, 2'b10 gives imm_i, and 2'b11 gives zero.
- R3: With dir_i = 0, each active PE i receives the value from the active PE with the largest index below i. With dir_i = 1, it receives from the active PE with the smallest index above i. PE i's word is bits [i*W +: W].
- R4: A bypassed PE (mask bit 0) drives nothing onto the network, and its received word and flag stay unchanged during a transfer.
- R5: An active PE with no active PE in the chosen direction receives zero and sets its no-neighbour flag. An active PE that does have a neighbour clears its flag.
- R6: A transfer with req_i high at a rising edge is captured on that same edge. done_o is 1 in the following cycle, and it returns to 0 after a cycle without req_i.
- R7: When every mask bit is 0, a request changes no received word and no flag.
- R8: When every PE is active, the transfer acts as a plain one-position shift with zero fill at the open end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Transfer request |
| dir_i | input | 1 | 0: receive from left (lower index), 1: from right |
| src_sel_i | input | 2 | Outgoing source select |
| mask_i | input | N | Per-PE active bit |
| reg_i | input | N*W | Per-PE register data |
| bcast_i | input | W | Broadcast word |
| imm_i | input | W | Immediate word |
| rx_o | output | N*W | Per-PE received word |
| nonb_o | output | N | Per-PE no-neighbour flag |
| done_o | output | 1 | Transfer completed last edge |

## Verification
Register-sourced transfers use distinct per-PE words, so a wrong hop, a wrong direction or a bypassed PE leaking onto the network shows up as a wrong value. Sparse masks with wide gaps, and a mask with a single active PE, separate true bypass from a plain shift. The single-PE case also covers the no-neighbour flag at both ends. Broadcast, immediate and the zero code use different constant words, so each select code gives a value that no other code gives. The all-off mask and back-to-back requests test retention and the done sequencing.

// File: rtl/bypnet_pkg.sv
package bypnet_pkg;
    typedef enum logic [1:0] {
        SRC_REG   = 2'b00,
        SRC_BCAST = 2'b01,
        SRC_IMM   = 2'b10,
        SRC_ZERO  = 2'b11
    } src_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } ctl_state_e;
endpackage

// File: rtl/bypnet_src_mux.sv
module bypnet_src_mux
    import bypnet_pkg::*;
#(
    parameter int W = 8
) (
    input  src_sel_e       sel_i,
    input  logic [W-1:0]   reg_i,
    input  logic [W-1:0]   bcast_i,
    input  logic [W-1:0]   imm_i,
    output logic [W-1:0]   out_o
);
    always_comb begin
        unique case (sel_i)
            SRC_REG:   out_o = reg_i;
            SRC_BCAST: out_o = bcast_i;
            SRC_IMM:   out_o = imm_i;
            SRC_ZERO:  out_o = '0;
            default:   out_o = '0;
        endcase
    end
endmodule

// File: rtl/bypnet_chain.sv
module bypnet_chain #(
    parameter int N = 8,
    parameter int W = 8
) (
    input  logic [N-1:0]   mask_i,
    input  logic [N*W-1:0] drv_i,
    output logic [N*W-1:0] from_left_o,
    output logic [N-1:0]   left_ok_o,
    output logic [N*W-1:0] from_right_o,
    output logic [N-1:0]   right_ok_o
);
    // Left-to-right sweep: nearest active PE at a lower index
    always_comb begin
        logic [W-1:0] carry;
        logic         seen;
        carry       = '0;
        seen        = 1'b0;
        from_left_o = '0;
        left_ok_o   = '0;
        for (int i = 0; i < N; i++) begin
            from_left_o[i*W +: W] = carry;
            left_ok_o[i]          = seen;
            if (mask_i[i]) begin
                carry = drv_i[i*W +: W];
                seen  = 1'b1;
            end
        end
    end

    // Right-to-left sweep: nearest active PE at a higher index
    always_comb begin
        logic [W-1:0] carry;
        logic         seen;
        carry        = '0;
        seen         = 1'b0;
        from_right_o = '0;
        right_ok_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            from_right_o[i*W +: W] = carry;
            right_ok_o[i]          = seen;
            if (mask_i[i]) begin
                carry = drv_i[i*W +: W];
                seen  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/bypnet_top.sv
module bypnet_top
    import bypnet_pkg::*;
#(
    parameter int N = 8,
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_i,
    input  logic           dir_i,
    input  logic [1:0]     src_sel_i,
    input  logic [N-1:0]   mask_i,
    input  logic [N*W-1:0] reg_i,
    input  logic [W-1:0]   bcast_i,
    input  logic [W-1:0]   imm_i,
    output logic [N*W-1:0] rx_o,
    output logic [N-1:0]   nonb_o,
    output logic           done_o
);
    localparam int BUS_W = N * W;

    ctl_state_e       state_q, state_d;
    src_sel_e         sel;
    logic [BUS_W-1:0] drv;
    logic [BUS_W-1:0] from_left, from_right;
    logic [N-1:0]     left_ok, right_ok;
    logic [BUS_W-1:0] rx_q;
    logic [N-1:0]     nonb_q;

    assign sel = src_sel_e'(src_sel_i);

    // One outgoing source selector per PE
    for (genvar g = 0; g < N; g++) begin : g_pe
        bypnet_src_mux #(.W(W)) u_mux (
            .sel_i   (sel),
            .reg_i   (reg_i[g*W +: W]),
            .bcast_i (bcast_i),
            .imm_i   (imm_i),
            .out_o   (drv[g*W +: W])
        );
    end

    bypnet_chain #(.N(N), .W(W)) u_chain (
        .mask_i       (mask_i),
        .drv_i        (drv),
        .from_left_o  (from_left),
        .left_ok_o    (left_ok),
        .from_right_o (from_right),
        .right_ok_o   (right_ok)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_i ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = req_i ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            ST_IDLE: done_o = 1'b0;
            ST_DONE: done_o = 1'b1;
            default: done_o = 1'b0;
        endcase
    end

    // Capture into active PEs on the request edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q   <= '0;
            nonb_q <= '0;
        end else if (req_i) begin
            for (int i = 0; i < N; i++) begin
                if (mask_i[i]) begin
                    if (dir_i) begin
                        rx_q[i*W +: W] <= right_ok[i] ? from_right[i*W +: W] : '0;
                        nonb_q[i]      <= ~right_ok[i];
                    end else begin
                        rx_q[i*W +: W] <= left_ok[i] ? from_left[i*W +: W] : '0;
                        nonb_q[i]      <= ~left_ok[i];
                    end
                end
            end
        end
    end

    assign rx_o   = rx_q;
    assign nonb_o = nonb_q;
endmodule

// File: rtl/bypnet_chk.sv
module bypnet_chk #(
    parameter int N = 8,
    parameter int W = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_i,
    input logic           dir_i,
    input logic [N-1:0]   mask_i,
    input logic [N*W-1:0] rx_o,
    input logic [N-1:0]   nonb_o,
    input logic           done_o
);
    // R6
    done_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> done_o);

    // R6
    done_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !done_o);

    // R5
    left_end_nonb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !dir_i && mask_i[0]) |=> (nonb_o[0] && rx_o[W-1:0] == '0));

    // R5
    right_end_nonb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && dir_i && mask_i[N-1]) |=> (nonb_o[N-1] && rx_o[N*W-1 -: W] == '0));

    for (genvar g = 0; g < N; g++) begin : g_pe
        // R4
        bypass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (req_i && !mask_i[g]) |=> ($stable(rx_o[g*W +: W]) && $stable(nonb_o[g])));

        // R5
        nonb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (req_i && mask_i[g]) |=> (!nonb_o[g] || rx_o[g*W +: W] == '0));

        // R6
        idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !req_i |=> ($stable(rx_o[g*W +: W]) && $stable(nonb_o[g])));
    end
endmodule

bind bypnet_top bypnet_chk #(.N(N), .W(W)) u_bypnet_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (req_i),
    .dir_i  (dir_i),
    .mask_i (mask_i),
    .rx_o   (rx_o),
    .nonb_o (nonb_o),
    .done_o (done_o)
);

// File: tb/test_bypnet_top.sv
`timescale 1ns/1ps
module test_bypnet_top;
    localparam int N = 8;
    localparam int W = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_i = 1'b0;
    logic           dir_i = 1'b0;
    logic [1:0]     src_sel_i = 2'b00;
    logic [N-1:0]   mask_i = '0;
    logic [N*W-1:0] reg_i = '0;
    logic [W-1:0]   bcast_i = '0;
    logic [W-1:0]   imm_i = '0;
    logic [N*W-1:0] rx_o;
    logic [N-1:0]   nonb_o;
    logic           done_o;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] exp_rx [N];
    logic         exp_nb [N];

    always #5 clk = ~clk;

    bypnet_top #(.N(N), .W(W)) i_bypnet_top (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .dir_i(dir_i),
        .src_sel_i(src_sel_i), .mask_i(mask_i), .reg_i(reg_i),
        .bcast_i(bcast_i), .imm_i(imm_i), .rx_o(rx_o),
        .nonb_o(nonb_o), .done_o(done_o)
    );

    task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] src_word(int i);
        case (src_sel_i)
            2'b00:   return reg_i[i*W +: W];
            2'b01:   return bcast_i;
            2'b10:   return imm_i;
            default: return '0;
        endcase
    endfunction

    // Model of one transfer, from the requirements
    task automatic model_step();
        logic [W-1:0] nv [N];
        logic         nf [N];
        for (int i = 0; i < N; i++) begin
            nv[i] = exp_rx[i];
            nf[i] = exp_nb[i];
            if (mask_i[i]) begin
                int j;
                j = -1;
                if (!dir_i) begin
                    for (int k = i - 1; k >= 0; k--)
                        if (j < 0 && mask_i[k]) j = k;
                end else begin
                    for (int k = i + 1; k < N; k++)
                        if (j < 0 && mask_i[k]) j = k;
                end
                nv[i] = (j < 0) ? '0 : src_word(j);
                nf[i] = (j < 0);
            end
        end
        for (int i = 0; i < N; i++) begin
            exp_rx[i] = nv[i];
            exp_nb[i] = nf[i];
        end
    endtask

    task automatic compare_all(string rq);
        for (int i = 0; i < N; i++) begin
            chk(rq, $sformatf("rx[%0d]", i), 32'(rx_o[i*W +: W]), 32'(exp_rx[i]));
            chk(rq, $sformatf("nonb[%0d]", i), 32'(nonb_o[i]), 32'(exp_nb[i]));
        end
    endtask

    // Inputs change at negedge; one-cycle request; check at the next negedge
    task automatic shift(string rq, logic [N-1:0] m, logic [1:0] sel, logic d);
        @(negedge clk);
        mask_i = m; src_sel_i = sel; dir_i = d; req_i = 1'b1;
        model_step();
        @(negedge clk);
        req_i = 1'b0;
        chk("R6", "done after request", 32'(done_o), 32'd1);
        compare_all(rq);
    endtask

    task automatic t_reset();
        for (int i = 0; i < N; i++) begin exp_rx[i] = '0; exp_nb[i] = 1'b0; end
        compare_all("R1");
        chk("R1", "done at reset", 32'(done_o), 32'd0);
    endtask

    task automatic t_full_shift();
        // R8 all active, both directions
        shift("R8", 8'hFF, 2'b00, 1'b0);
        shift("R8", 8'hFF, 2'b00, 1'b1);
    endtask

    task automatic t_sparse();
        // R3 wide gaps between active PEs
        shift("R3", 8'b1001_0010, 2'b00, 1'b0);
        shift("R3", 8'b0100_1001, 2'b00, 1'b1);
        shift("R4", 8'b0010_0100, 2'b00, 1'b0);
    endtask

    task automatic t_single();
        // R5 a lone active PE has no neighbour either way
        shift("R5", 8'b0001_0000, 2'b00, 1'b0);
        shift("R5", 8'b0000_1000, 2'b00, 1'b1);
    endtask

    task automatic t_sources();
        // R2 each select code
        shift("R2", 8'b1010_0101, 2'b01, 1'b0);
        shift("R2", 8'b1010_0101, 2'b10, 1'b1);
        shift("R2", 8'b0111_1110, 2'b11, 1'b0);
    endtask

    task automatic t_all_off();
        // R7 nothing changes
        shift("R7", 8'h00, 2'b01, 1'b1);
    endtask

    task automatic t_done_seq();
        // R6 back-to-back requests, then idle
        @(negedge clk);
        mask_i = 8'hF0; src_sel_i = 2'b00; dir_i = 1'b0; req_i = 1'b1;
        model_step();
        @(negedge clk);
        mask_i = 8'h0F; dir_i = 1'b1;
        model_step();
        chk("R6", "done first", 32'(done_o), 32'd1);
        @(negedge clk);
        req_i = 1'b0;
        chk("R6", "done second", 32'(done_o), 32'd1);
        compare_all("R6");
        @(negedge clk);
        chk("R6", "done drops", 32'(done_o), 32'd0);
        compare_all("R6");
    endtask

    initial begin
        for (int i = 0; i < N; i++) reg_i[i*W +: W] = W'(8'h11 * (i + 1));
        bcast_i = 8'hA5;
        imm_i   = 8'h3C;
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full_shift();
        t_sparse();
        t_single();
        t_sources();
        t_all_off();
        t_done_seq();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule